// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address for each beat of a four-beat burst in a synchronous burst memory. When a burst begins, the external address is captured. The upper bits of the captured address are then held. The two low bits step through one of two beat orders as the burst advances.

A mode input selects the beat order. Driven high, or left undriven with a pull-up at the pin, it selects interleaved order: each beat address is the start bits XOR the beat index. Driven low, it selects linear order: the start bits plus the beat index, wrapping within the four-beat block. The mode is captured only while reset is held and stays fixed afterwards. The memory array, chip-select decoding and output-enable control lie outside this block.

Either of two address strobes begins a burst. An advance input moves to the next beat. With advance low and no strobe, the current address is kept.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low and in the cycles after it rises until a strobe arrives, `addr_o` is all zeros.
- R2: A rising clock edge with `strb_a_i` or `strb_b_i` high loads `ext_addr_i`; from the next cycle `addr_o` equals the loaded value (beat index 0). A strobe takes priority over `adv_i` in the same cycle.
- R3: With interleaved order selected (mode high during reset), the low two bits of `addr_o` at beat index k equal the start bits XOR k, for k = 0,1,2,3.
- R4: With linear order selected (mode low during reset), the low two bits at beat index k equal (start bits + k) mod 4.
- R5: An edge with `adv_i` low and no strobe leaves `addr_o` unchanged.
- R6: Each edge with `adv_i` high and no strobe raises the beat index by one. After index 3 it returns to 0, so the sequence repeats from the start bits and no error is raised.
- R7: The bits of `addr_o` above the low two stay equal to the loaded address for the whole burst, whatever `ext_addr_i` does between strobes.
- R8: `mode_i` is sampled only on edges where `rst_n` is low. Changes to it while out of reset have no effect on the beat order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; also the window in which the mode is captured |
| mode_i | input | 1 | Beat order: 1 interleaved, 0 linear |
| strb_a_i | input | 1 | First address strobe; begins a burst |
| strb_b_i | input | 1 | Second address strobe; begins a burst |
| adv_i | input | 1 | Step to the next beat |
| ext_addr_i | input | ADDR_W | External address captured at burst start |
| addr_o | output | ADDR_W | Current beat address |

## Verification
The bench builds the block with `ADDR_W` = 12 and the default `BEAT_W` = 2. The upper ten bits are then wide enough to show that a changing external address does not leak through between strobes. All four start values are run in both orders through five advances, so the wrap back to the start beat and the repeat that follows it are observed. Further scenarios cover holding through suspended cycles, a strobe together with advance, each strobe on its own, and toggling the mode pin after reset.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_mode_latch.sv
module burst_mode_latch
  import burst_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   mode_i,
  output order_e order_o
);
  order_e order_q;

  // Captured only while reset is held; frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) order_q <= order_e'(mode_i);
  end

  assign order_o = order_q;

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(order_q)); // R8
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = '1;

  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       beat_q <= '0;
    else if (clear_i) beat_q <= '0;
    else if (step_i)  beat_q <= beat_q + 1'b1;
  end

  assign beat_o = beat_q;

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> beat_q == '0); // R2
  AST_WRAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clear_i && beat_q == LAST_BEAT) |=> beat_q == '0); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clear_i) |=> $stable(beat_q)); // R5
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  order_e            order_i,
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [BEAT_W-1:0] low_o
);
  // Interleaved order: each index bit flips the matching start bit.
  function automatic logic [BEAT_W-1:0] interleave_of(
    input logic [BEAT_W-1:0] s, input logic [BEAT_W-1:0] k);
    return s ^ k;
  endfunction

  // Linear order: add within the aligned block, carry out is dropped.
  function automatic logic [BEAT_W-1:0] linear_of(
    input logic [BEAT_W-1:0] s, input logic [BEAT_W-1:0] k);
    return s + k;
  endfunction

  logic [BEAT_W-1:0] il_w;
  logic [BEAT_W-1:0] ln_w;

  assign il_w  = interleave_of(start_i, beat_i);
  assign ln_w  = linear_of(start_i, beat_i);
  assign low_o = (order_i == ORD_INTERLEAVE) ? il_w : ln_w;

  // At index 0 both orders give back the start bits.
  always_comb begin
    if (beat_i == '0) begin
      AST_FIRST_BEAT_IS_START: assert (low_o == start_i); // R2
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              strb_a_i,
  input  logic              strb_b_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  // Named events for the assertions.
  logic   begin_w;
  logic   step_w;
  order_e order_w;

  logic [UPPER_W-1:0] upper_q;
  logic [BEAT_W-1:0]  start_q;
  logic [BEAT_W-1:0]  beat_w;
  logic [BEAT_W-1:0]  low_w;

  assign begin_w = strb_a_i | strb_b_i;
  assign step_w  = adv_i & ~begin_w;

  burst_mode_latch u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .order_o (order_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
    end else if (begin_w) begin
      upper_q <= ext_addr_i[ADDR_W-1:BEAT_W];
      start_q <= ext_addr_i[BEAT_W-1:0];
    end
  end

  burst_beat_counter #(.BEAT_W(BEAT_W)) u_beat (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (begin_w),
    .step_i  (step_w),
    .beat_o  (beat_w)
  );

  burst_addr_map #(.BEAT_W(BEAT_W)) u_map (
    .order_i (order_w),
    .start_i (start_q),
    .beat_i  (beat_w),
    .low_o   (low_w)
  );

  assign addr_o = {upper_q, low_w};

  AST_LOAD_EXT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    begin_w |=> addr_o == $past(ext_addr_i)); // R2
  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!begin_w && !adv_i) |=> $stable(addr_o)); // R5
  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !begin_w |=> $stable(addr_o[ADDR_W-1:BEAT_W])); // R7
  AST_ADVANCE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    step_w |=> !$stable(addr_o[BEAT_W-1:0])); // R6
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_i = 1'b1;
  logic          strb_a_i = 1'b0;
  logic          strb_b_i = 1'b0;
  logic          adv_i = 1'b0;
  logic [AW-1:0] ext_addr_i = '0;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .strb_a_i(strb_a_i), .strb_b_i(strb_b_i), .adv_i(adv_i),
    .ext_addr_i(ext_addr_i), .addr_o(addr_o)
  );

  task automatic check(input string req, input logic [AW-1:0] got, input logic [AW-1:0] want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: addr_o=%h expected %h", req, got, want);
    end
  endtask

  // Expected beat address, written from the requirement text.
  function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] base, input int k, input bit il);
    int s, lo;
    s = int'(base[1:0]);
    if (il) lo = ((s / 2) ^ ((k / 2) % 2)) * 2 + ((s % 2) ^ (k % 2));
    else    lo = (s + k) % 4;
    return {base[AW-1:2], 2'(lo)};
  endfunction

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst_n = 1'b0; mode_i = m; strb_a_i = 0; strb_b_i = 0; adv_i = 0;
    ext_addr_i = 12'hABC;
    check("R1", addr_o, addr_o); // placeholder-free sync point
    repeat (3) @(negedge clk);
    check("R1", addr_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", addr_o, '0);
  endtask

  task automatic load(input logic [AW-1:0] a, input bit use_b);
    strb_a_i = !use_b; strb_b_i = use_b; adv_i = 0; ext_addr_i = a;
    @(negedge clk);
    strb_a_i = 0; strb_b_i = 0;
    check("R2", addr_o, a);
  endtask

  // Five advances: beats 1,2,3, wrap to 0, then 1 again.
  task automatic run_burst(input logic [AW-1:0] a, input bit il, input bit use_b);
    load(a, use_b);
    for (int k = 1; k <= 5; k++) begin
      adv_i = 1; ext_addr_i = ~a;
      @(negedge clk);
      check(il ? "R3/R6/R7" : "R4/R6/R7", addr_o, expect_addr(a, k % 4, il));
    end
    adv_i = 0;
  endtask

  task automatic suspend_test(input bit il);
    logic [AW-1:0] a = 12'h5A6;
    load(a, 0);
    adv_i = 1; @(negedge clk);
    check("R5", addr_o, expect_addr(a, 1, il));
    adv_i = 0;
    for (int i = 0; i < 3; i++) begin
      ext_addr_i = 12'h0F3 + 12'(i);
      @(negedge clk);
      check("R5", addr_o, expect_addr(a, 1, il));
    end
    adv_i = 1; @(negedge clk);
    check("R5", addr_o, expect_addr(a, 2, il));
    adv_i = 0;
  endtask

  task automatic priority_test(input bit il);
    logic [AW-1:0] a = 12'h3C1;
    load(12'h111, 0);
    adv_i = 1; strb_b_i = 1; ext_addr_i = a;
    @(negedge clk);
    strb_b_i = 0; adv_i = 0;
    check("R2", addr_o, a);
    adv_i = 1; @(negedge clk); adv_i = 0;
    check("R2", addr_o, expect_addr(a, 1, il));
  endtask

  task automatic mode_freeze_test;
    do_reset(1'b1);
    mode_i = 1'b0;
    run_burst(12'h701, 1'b1, 0);
    do_reset(1'b0);
    mode_i = 1'b1;
    run_burst(12'h701, 1'b0, 1);
    check("R8", {11'd0, mode_i}, 12'd1);
  endtask

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: addr_o=%h expected completion", addr_o);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    for (int s = 0; s < 4; s++) run_burst({10'h2D5, 2'(s)}, 1'b1, s[0]);
    suspend_test(1'b1);
    priority_test(1'b1);
    do_reset(1'b0);
    for (int s = 0; s < 4; s++) run_burst({10'h0B3, 2'(s)}, 1'b0, !s[0]);
    suspend_test(1'b0);
    priority_test(1'b0);
    mode_freeze_test();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule